// File: doc/BRIEF.md
# Multiframe Clock Counter with SYSREF Alignment

This block keeps the local multiframe clock for a deterministic-latency serial converter link. It runs in the link clock domain and counts link-clock beats across one multiframe. Each beat carries four octets per lane, so one multiframe lasts F*K/4 beats, where F (octets per frame) and K (frames per multiframe) are configuration inputs. A one-beat boundary pulse marks the start of every multiframe.

An external SYSREF reference pulse sets the phase of the count. The block samples SYSREF once. A rising edge in the sampled stream restarts the counter, so that the multiframe boundary follows the reference. In continuous mode every edge is honoured. An edge that would move the boundary sets a sticky misalignment flag. An edge that coincides with the natural wrap changes nothing. In single-capture mode only the first edge after reset is used. Until that first edge arrives, the counter is idle.

A single status word can be read back. It holds the live-alignment bit, the misalignment flag, the single-capture-pending bit and a snapshot of the count. Writing a 1 to the flag position clears the misalignment flag.

Top module: `lmfc_align_top`

## Requirements
- R1: The multiframe length is L = cfgOctets*cfgFrames/4 beats. Once aligned, lmfcCount steps up by one every clock and wraps from L-1 to 0.
- R2: lmfcPulse is high exactly in the cycles where the block is aligned and lmfcCount is 0.
- R3: After reset and until the first accepted SYSREF edge, lmfcCount is 0 and lmfcPulse is low.
- R4: A SYSREF edge is a clock where sysrefIn is sampled high after being sampled low. If the edge is accepted, lmfcCount reads 0 and lmfcPulse reads 1 after the clock that follows that sample. The count then carries on from 0.
- R5: An accepted edge that arrives while the block is aligned, with restart landing on the beat where the count would wrap anyway, leaves the count sequence unchanged and does not set alignErr.
- R6: In continuous mode (cfgSingleDet=0), an accepted edge that arrives while aligned and not on a wrap beat restarts the count and sets alignErr.
- R7: alignErr stays set until a write (regWrEn) with regWrData bit 1 equal to 1. A write with that bit equal to 0 leaves it set.
- R8: With cfgSingleDet=1, SYSREF edges after the first accepted one are ignored. The count continues and alignErr stays 0.
- R9: singleDetPending is 1 from reset and falls to 0 on the first accepted edge. The same bit appears at bit 2 of the status word.
- R10: The status word has the aligned bit at bit 0, alignErr at bit 1, the pending bit at bit 2 and lmfcCount at bits [10:3]. All other bits are 0. It appears on regRdData after the clock that samples regRdEn high, and it shows the state before that clock.
- R11: Holding sysrefIn high for several clocks counts as one edge only. There is no further restart while it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sysrefIn | input | 1 | Reference pulse, synchronous to clk |
| cfgOctets | input | 4 | Octets per frame (F) |
| cfgFrames | input | 6 | Frames per multiframe (K) |
| cfgSingleDet | input | 1 | 1 = honour only the first SYSREF edge |
| regRdEn | input | 1 | Status read strobe |
| regWrEn | input | 1 | Status write strobe |
| regWrData | input | 32 | Write data; bit 1 set clears alignErr |
| regRdData | output | 32 | Status word |
| lmfcPulse | output | 1 | Multiframe boundary pulse |
| lmfcCount | output | 8 | Beat index inside the multiframe |
| singleDetPending | output | 1 | First SYSREF edge not yet accepted |
| alignErr | output | 1 | Sticky misalignment flag |

## Verification
A SYSREF level first sampled at clock N causes the restart at clock N+1. The count therefore reads 0, with the pulse high, after the second edge following the drive. A status read sampled at one clock is visible after that clock. A write clear takes effect at the clock where it is sampled.

The bench keeps a beat-level model that advances on the same clock edges. It compares count, pulse and flags at every falling edge. A queue carries each expected status word from the read driver to a monitor, which compares it one clock later. Directed checks confirm the restart timing, the hold-high case and the aligned and misaligned edge placements.

// File: rtl/lmfc_align_pkg.sv
package lmfc_align_pkg;
  // Strobes from control into the counting datapath
  typedef struct packed {
    logic restart;  // realign: count to zero this clock
    logic run;      // aligned: counter advances
  } lmfcStrobe_t;

  localparam int BIT_ALIGNED = 0;
  localparam int BIT_ERR     = 1;
  localparam int BIT_PEND    = 2;
  localparam int CNT_LSB     = 3;
endpackage

// File: rtl/lmfc_align_dp.sv
module lmfc_align_dp
  import lmfc_align_pkg::*;
#(
  parameter int F_W = 4,
  parameter int K_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  lmfcStrobe_t          strobe,
  input  logic [F_W-1:0]       cfgF,
  input  logic [K_W-1:0]       cfgK,
  output logic [F_W+K_W-3:0]   count,
  output logic                 pulse,
  output logic                 atLast
);
  localparam int PROD_W = F_W + K_W;
  localparam int CNT_W  = PROD_W - 2;

  logic [PROD_W-1:0] product;
  logic [CNT_W-1:0]  lenM1;

  // four octets per beat: length = F*K/4
  always_comb begin
    product = PROD_W'(cfgF) * PROD_W'(cfgK);
    lenM1   = product[PROD_W-1:2] - CNT_W'(1);
  end

  assign atLast = (count >= lenM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      pulse <= 1'b0;
    end else begin
      if (strobe.restart) begin
        count <= '0;
      end else if (strobe.run) begin
        count <= atLast ? '0 : count + CNT_W'(1);
      end
      pulse <= strobe.restart | (strobe.run & atLast);
    end
  end

  // R1: count stays inside the multiframe while configuration holds
  a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(cfgF) && $stable(cfgK)) |-> (count <= lenM1));
  // R4: a restart strobe lands the count on zero
  a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (count == '0));
  // R2: boundary pulse only on beat zero
  a_r2_pulse_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    pulse |-> (count == '0));
  // R3: idle until aligned
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.restart) |=> (count == '0 && !pulse));
endmodule

// File: rtl/lmfc_align_ctrl.sv
module lmfc_align_ctrl
  import lmfc_align_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysrefIn,
  input  logic              singleMode,
  input  logic              atLast,
  input  logic [CNT_W-1:0]  count,
  input  logic              rdEn,
  input  logic              wrClr,
  output lmfcStrobe_t       strobe,
  output logic              pending,
  output logic              errFlag,
  output logic [DATA_W-1:0] rdData
);
  logic sampleNow, samplePrev, seen, edgeHit, accept;
  logic [DATA_W-1:0] statusWord;

  assign edgeHit = sampleNow & ~samplePrev;
  assign accept  = edgeHit & ~(singleMode & seen);

  assign strobe.restart = accept;
  assign strobe.run     = seen;
  assign pending        = ~seen;

  always_comb begin
    statusWord                    = '0;
    statusWord[BIT_ALIGNED]       = seen;
    statusWord[BIT_ERR]           = errFlag;
    statusWord[BIT_PEND]          = ~seen;
    statusWord[CNT_LSB +: CNT_W]  = count;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleNow  <= 1'b0;
      samplePrev <= 1'b0;
      seen       <= 1'b0;
      errFlag    <= 1'b0;
      rdData     <= '0;
    end else begin
      sampleNow  <= sysrefIn;
      samplePrev <= sampleNow;
      if (accept) seen <= 1'b1;
      if (accept && seen && !atLast) errFlag <= 1'b1;
      else if (wrClr)                errFlag <= 1'b0;
      if (rdEn) rdData <= statusWord;
    end
  end

  // R7: flag holds until a clearing write
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !wrClr) |=> errFlag);
  // R9: pending never returns once cleared
  a_r9_pending_falls_once: assert property (@(posedge clk) disable iff (!rstN)
    !pending |=> !pending);
  // R11: a held-high level gives no second restart
  a_r11_no_retrigger: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> !strobe.restart);
endmodule

// File: rtl/lmfc_align_top.sv
module lmfc_align_top
  import lmfc_align_pkg::*;
#(
  parameter int F_W    = 4,
  parameter int K_W    = 6,
  parameter int DATA_W = 32,
  localparam int CNT_W = F_W + K_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysrefIn,
  input  logic [F_W-1:0]    cfgOctets,
  input  logic [K_W-1:0]    cfgFrames,
  input  logic              cfgSingleDet,
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              lmfcPulse,
  output logic [CNT_W-1:0]  lmfcCount,
  output logic              singleDetPending,
  output logic              alignErr
);
  lmfcStrobe_t strobe;
  logic        atLast;
  logic        wrClr;

  assign wrClr = regWrEn & regWrData[BIT_ERR];

  lmfc_align_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sysrefIn(sysrefIn), .singleMode(cfgSingleDet),
    .atLast(atLast), .count(lmfcCount), .rdEn(regRdEn), .wrClr(wrClr),
    .strobe(strobe), .pending(singleDetPending), .errFlag(alignErr),
    .rdData(regRdData)
  );

  lmfc_align_dp #(.F_W(F_W), .K_W(K_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgF(cfgOctets), .cfgK(cfgFrames),
    .count(lmfcCount), .pulse(lmfcPulse), .atLast(atLast)
  );
endmodule

// File: tb/lmfc_align_top_tb_top.sv
module lmfc_align_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sysrefIn = 1'b0;
  logic [3:0] cfgOctets = 4'd4;
  logic [5:0] cfgFrames = 6'd32;
  logic cfgSingleDet = 1'b0;
  logic regRdEn = 1'b0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic lmfcPulse;
  logic [7:0] lmfcCount;
  logic singleDetPending;
  logic alignErr;

  always #4 clk = ~clk;  // 125 MHz

  lmfc_align_top dut_i (
    .clk(clk), .rstN(rstN), .sysrefIn(sysrefIn), .cfgOctets(cfgOctets),
    .cfgFrames(cfgFrames), .cfgSingleDet(cfgSingleDet), .regRdEn(regRdEn),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .lmfcPulse(lmfcPulse), .lmfcCount(lmfcCount),
    .singleDetPending(singleDetPending), .alignErr(alignErr)
  );

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Beat-level model derived from the requirements
  int  mCnt = 0;
  bit  mSeen = 0, mErr = 0, mS1 = 0, mS2 = 0;
  bit  rdDly = 0;

  always @(posedge clk) begin
    int  len;
    bit  acc;
    len = (int'(cfgOctets) * int'(cfgFrames)) / 4;
    if (!rstN) begin
      mCnt = 0; mSeen = 0; mErr = 0; mS1 = 0; mS2 = 0; rdDly = 0;
    end else begin
      acc = mS1 && !mS2 && !(cfgSingleDet && mSeen);
      if (regWrEn && regWrData[1]) mErr = 0;
      if (acc && mSeen && mCnt != len - 1) mErr = 1;
      if (acc) mCnt = 0;
      else if (mSeen) mCnt = (mCnt >= len - 1) ? 0 : mCnt + 1;
      if (acc) mSeen = 1;
      mS2 = mS1;
      mS1 = sysrefIn;
      rdDly = regRdEn;
    end
  end

  // Scoreboard queue of expected status words
  logic [31:0] expQ[$];
  string       tagQ[$];

  function automatic logic [31:0] modelWord();
    return (32'(mCnt) << 3) | (32'(!mSeen) << 2) | (32'(mErr) << 1) | 32'(mSeen);
  endfunction

  // Monitor: per-cycle model compare and status-word pops
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R1 count", int'(lmfcCount), mCnt);
      check("R2 pulse", int'(lmfcPulse), int'(mSeen && mCnt == 0));
      check("R6 alignErr", int'(alignErr), int'(mErr));
      check("R9 pending", int'(singleDetPending), int'(!mSeen));
      if (rdDly && expQ.size() > 0) begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, int'(regRdData), int'(e));
      end
    end
  end

  task automatic doRead(input string tag);
    @(negedge clk);
    regRdEn = 1'b1;
    expQ.push_back(modelWord());
    tagQ.push_back(tag);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic doWrite(input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    regWrData = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseSysref();
    @(negedge clk);
    sysrefIn = 1'b1;
    @(negedge clk);
    sysrefIn = 1'b0;
  endtask

  task automatic waitCount(input int v);
    int guard;
    guard = 0;
    while (int'(lmfcCount) != v && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic applyReset(input bit single);
    @(negedge clk);
    rstN = 1'b0;
    cfgSingleDet = single;
    sysrefIn = 1'b0;
    idle(3);
    rstN = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin : driver
    applyReset(1'b0);
    idle(5);
    // R3, R9, R10: reset state read back: only pending bit set
    check("R3 idle count", int'(lmfcCount), 0);
    check("R3 idle pulse", int'(lmfcPulse), 0);
    doRead("R10 reset word");
    idle(1);
    check("R10 reset word direct", int'(regRdData), 32'h4);

    // R4, R11: first edge, held high for five clocks
    @(negedge clk);
    sysrefIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R4 count zero", int'(lmfcCount), 0);
    check("R4 pulse", int'(lmfcPulse), 1);
    idle(3);
    check("R11 no retrigger", int'(lmfcCount), 3);
    sysrefIn = 1'b0;
    idle(70);  // R1 wrap at 32 beats
    doRead("R10 aligned word");

    // R5: edge landing on the natural wrap
    waitCount(30);
    sysrefIn = 1'b1;
    @(negedge clk);
    sysrefIn = 1'b0;
    idle(4);
    check("R5 no error", int'(alignErr), 0);
    doRead("R5 word");

    // R6: misaligned edge
    waitCount(5);
    sysrefIn = 1'b1;
    @(negedge clk);
    sysrefIn = 1'b0;
    @(negedge clk);
    check("R6 realigned count", int'(lmfcCount), 0);
    check("R6 flag set", int'(alignErr), 1);
    doRead("R6 word");

    // R7: clear only by bit 1
    doWrite(32'hFFFF_FFFD);
    idle(1);
    check("R7 kept", int'(alignErr), 1);
    doWrite(32'h2);
    idle(1);
    check("R7 cleared", int'(alignErr), 0);
    doRead("R7 word");

    // R1: other lengths (16 and 8 beats), misaligned edge per length
    cfgOctets = 4'd2;
    idle(50);
    pulseSysref();
    idle(40);
    doRead("R1 len16 word");
    cfgOctets = 4'd1;
    idle(30);
    waitCount(6);
    pulseSysref();
    idle(20);
    doRead("R1 len8 word");
    cfgOctets = 4'd8;
    idle(150);
    doRead("R1 len64 word");

    // R8, R9: single-capture mode
    applyReset(1'b1);
    cfgOctets = 4'd4;
    idle(4);
    doRead("R9 pending word");
    pulseSysref();
    idle(12);
    check("R9 pending cleared", int'(singleDetPending), 0);
    waitCount(10);
    pulseSysref();
    @(negedge clk);
    check("R8 ignored count", int'(lmfcCount), 13);
    check("R8 no error", int'(alignErr), 0);
    idle(40);
    doRead("R8 word");

    idle(3);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule